// File: doc/BRIEF.md
# I2C Byte-Packing Data Buffer

This block stages data between a 16-bit register port and a byte-wide I2C engine. It holds up to four bytes in one shift register. Software loads transmit data as halfwords, plus one optional single byte at the end of a transfer. It reads received data back as halfwords. One order input decides whether the earlier byte of a halfword sits in the upper or the lower half. This applies the same way to writes and to reads.

The engine drains transmit bytes oldest first through a pop strobe. It pushes received bytes through a push strobe, and they fill the register from the low lane upward. The block keeps separate transmit and receive byte counts. After each access it emits one-cycle set or clear pulses for the controller's status flags: transmit-ready, transmit-underflow, receive-ready, receive-overrun, single-byte-left and access-ready. It also emits a pulse that clears the controller's master bit. Counts and pulses are registered, so they appear in the cycle after the strobe. Read data and the outgoing transmit byte are combinational from the current contents.

Top module: `i2c_pack_buf`

## Requirements
- R1: After reset both counts are 0, every status pulse is low, and `rdata_o` and `tx_byte_o` are 0.
- R2: A halfword write with transmit count ≤ 2 shifts the register left by 16, inserts the halfword in lanes 1:0 and adds 2 to the transmit count. With `big_endian_i`=1 the halfword is stored as given, so bits 15:8 are transmitted first. With 0 the two bytes are swapped on entry, so bits 7:0 are transmitted first.
- R3: A byte write with transmit count ≤ 2 shifts left by 8, inserts `wdata_i[7:0]` in lane 0 and adds 1 to the transmit count.
- R4: A halfword or byte write while the transmit count exceeds 2 is ignored. Contents, counts and pulses are unchanged.
- R5: Every accepted write pulses `tx_undf_clr_o`. It also pulses `tx_ready_clr_o` exactly when the new transmit count exceeds 2.
- R6: `tx_byte_o` shows lane (transmit count − 1), which is the oldest unsent byte. A pop decrements the count. A pop at count 0 does nothing and `tx_byte_o` is 0.
- R7: A push writes `rx_byte_i` into lane (receive count) and increments the count. A push at count 4 is ignored.
- R8: `rdata_o` is {lane1, lane0} when `big_endian_i`=0 and {lane0, lane1} when it is 1. A read with 2 or more bytes held subtracts 2 from the receive count. It also shifts the register right by 16 when more than 2 bytes were held.
- R9: A read with exactly 1 byte held pulses `single_set_o` and sets the receive count to 0.
- R10: Every read pulses `rx_ovr_clr_o`. A read that leaves the receive count at 0 pulses `rx_ready_clr_o`. If `master_rx_i` is high during that read, it also pulses `acc_ready_set_o` and `master_clr_o`.
- R11: A read at receive count 0 returns the current low halfword and changes no count.
- R12: `start_i` clears the whole register and both counts.
- R13: When several strobes are high in one cycle, only one acts, in this priority: start, halfword write, byte write, read, pop, push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | 1: earlier byte in bits 15:8 of a halfword |
| master_rx_i | input | 1 | Controller is currently master receiver |
| start_i | input | 1 | New transfer: clear buffer and counts |
| wr_half_i | input | 1 | Halfword data write strobe |
| wr_byte_i | input | 1 | Byte data write strobe (uses bits 7:0) |
| wdata_i | input | 16 | Write data |
| rd_i | input | 1 | Data read strobe |
| rdata_o | output | 16 | Read data, valid in the strobe cycle |
| tx_pop_i | input | 1 | Engine takes one transmit byte |
| tx_byte_o | output | 8 | Oldest pending transmit byte |
| tx_cnt_o | output | 3 | Pending transmit bytes |
| rx_push_i | input | 1 | Engine delivers one received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_cnt_o | output | 3 | Held received bytes |
| tx_ready_clr_o | output | 1 | Clear transmit-ready flag |
| tx_undf_clr_o | output | 1 | Clear transmit-underflow flag |
| rx_ready_clr_o | output | 1 | Clear receive-ready flag |
| rx_ovr_clr_o | output | 1 | Clear receive-overrun flag |
| single_set_o | output | 1 | Set single-byte-left flag |
| acc_ready_set_o | output | 1 | Set access-ready flag |
| master_clr_o | output | 1 | Clear the controller's master bit |

## Verification
The hardest state to reach is a read that leaves exactly one byte behind. Only a three-byte receive followed by a halfword read produces it, and the next read must then raise the single-byte pulse with the shifted-down byte in the low lane. The stimulus table pushes three bytes and reads twice to land there. A directed test repeats the one-byte read with the master-receiver input high, so that the access-ready and master-clear pulses coincide with it. Ignored writes are reached by loading three bytes through a halfword write plus a byte write, then writing again and draining to show the contents survived.

// File: rtl/i2c_pack_pkg.sv
package i2c_pack_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_START, OP_WR_HALF, OP_WR_BYTE, OP_RD, OP_POP, OP_PUSH
  } pack_op_e;

  typedef struct packed {
    logic tx_ready_clr;
    logic tx_undf_clr;
    logic rx_ready_clr;
    logic rx_ovr_clr;
    logic single_set;
    logic acc_ready_set;
    logic master_clr;
  } pack_flag_t;
endpackage

// File: rtl/i2c_pack_swap.sv
module i2c_pack_swap #(
  parameter int BW        = 8,
  parameter bit SWAP_WHEN = 1'b0
) (
  input  logic            order_i,
  input  logic [2*BW-1:0] d_i,
  output logic [2*BW-1:0] d_o
);
  assign d_o = (order_i == SWAP_WHEN) ? {d_i[BW-1:0], d_i[2*BW-1:BW]} : d_i;
endmodule

// File: rtl/i2c_pack_ctrl.sv
module i2c_pack_ctrl import i2c_pack_pkg::*; #(
  parameter int BYTES = 4,
  parameter int CW    = $clog2(BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_half_i,
  input  logic          wr_byte_i,
  input  logic          rd_i,
  input  logic          tx_pop_i,
  input  logic          rx_push_i,
  input  logic          master_rx_i,
  output pack_op_e      op_o,
  output logic [CW-1:0] tx_cnt_o,
  output logic [CW-1:0] rx_cnt_o,
  output pack_flag_t    flag_o
);
  localparam logic [CW-1:0] C1   = CW'(1);
  localparam logic [CW-1:0] C2   = CW'(2);
  localparam logic [CW-1:0] CMAX = CW'(BYTES);
  localparam logic [CW-1:0] ROOM = CW'(BYTES - 2);

  logic [CW-1:0] tx_q, rx_q, tx_d, rx_d;
  pack_flag_t    flag_d, flag_q;
  pack_op_e      op;
  logic          wr_ok;

  assign wr_ok = (tx_q <= ROOM);

  // fixed priority; a refused write is a no-op
  always_comb begin
    if (start_i)        op = OP_START;
    else if (wr_half_i) op = wr_ok ? OP_WR_HALF : OP_NONE;
    else if (wr_byte_i) op = wr_ok ? OP_WR_BYTE : OP_NONE;
    else if (rd_i)      op = OP_RD;
    else if (tx_pop_i)  op = (tx_q != '0) ? OP_POP : OP_NONE;
    else if (rx_push_i) op = (rx_q != CMAX) ? OP_PUSH : OP_NONE;
    else                op = OP_NONE;
  end

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    flag_d = '0;
    unique case (op)
      OP_START:   begin tx_d = '0; rx_d = '0; end
      OP_WR_HALF: tx_d = tx_q + C2;
      OP_WR_BYTE: tx_d = tx_q + C1;
      OP_POP:     tx_d = tx_q - C1;
      OP_PUSH:    rx_d = rx_q + C1;
      OP_RD: begin
        if (rx_q == C1)     rx_d = '0;
        else if (rx_q > C1) rx_d = rx_q - C2;
      end
      default: ;
    endcase
    if (op == OP_WR_HALF || op == OP_WR_BYTE) begin
      flag_d.tx_undf_clr  = 1'b1;
      flag_d.tx_ready_clr = (tx_d > ROOM);
    end
    if (op == OP_RD) begin
      flag_d.rx_ovr_clr = 1'b1;
      flag_d.single_set = (rx_q == C1);
      if (rx_d == '0) begin
        flag_d.rx_ready_clr  = 1'b1;
        flag_d.acc_ready_set = master_rx_i;
        flag_d.master_clr    = master_rx_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      flag_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      flag_q <= flag_d;
    end
  end

  assign op_o     = op;
  assign tx_cnt_o = tx_q;
  assign rx_cnt_o = rx_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/i2c_pack_store.sv
module i2c_pack_store import i2c_pack_pkg::*; #(
  parameter int BW    = 8,
  parameter int BYTES = 4,
  parameter int CW    = $clog2(BYTES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pack_op_e        op_i,
  input  logic [2*BW-1:0] half_i,
  input  logic [BW-1:0]   byte_i,
  input  logic [BW-1:0]   push_i,
  input  logic [CW-1:0]   tx_cnt_i,
  input  logic [CW-1:0]   rx_cnt_i,
  output logic [BW-1:0]   tx_byte_o,
  output logic [2*BW-1:0] low_o
);
  localparam int DW = BW * BYTES;
  localparam int HW = 2 * BW;
  localparam logic [CW-1:0] C2 = CW'(2);

  logic [DW-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    unique case (op_i)
      OP_START:   data_d = '0;
      OP_WR_HALF: data_d = {data_q[DW-HW-1:0], half_i};
      OP_WR_BYTE: data_d = {data_q[DW-BW-1:0], byte_i};
      OP_RD:      if (rx_cnt_i > C2) data_d = data_q >> HW;
      OP_PUSH: begin
        for (int g = 0; g < BYTES; g++)
          if (rx_cnt_i == CW'(g)) data_d[g*BW +: BW] = push_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  // oldest pending byte sits at the highest occupied lane
  always_comb begin
    tx_byte_o = '0;
    for (int g = 0; g < BYTES; g++)
      if (tx_cnt_i == CW'(g + 1)) tx_byte_o = data_q[g*BW +: BW];
  end

  assign low_o = data_q[HW-1:0];
endmodule

// File: rtl/i2c_pack_buf.sv
module i2c_pack_buf import i2c_pack_pkg::*; #(
  parameter int BW    = 8,
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            big_endian_i,
  input  logic            master_rx_i,
  input  logic            start_i,
  input  logic            wr_half_i,
  input  logic            wr_byte_i,
  input  logic [2*BW-1:0] wdata_i,
  input  logic            rd_i,
  output logic [2*BW-1:0] rdata_o,
  input  logic            tx_pop_i,
  output logic [BW-1:0]   tx_byte_o,
  output logic [CW-1:0]   tx_cnt_o,
  input  logic            rx_push_i,
  input  logic [BW-1:0]   rx_byte_i,
  output logic [CW-1:0]   rx_cnt_o,
  output logic            tx_ready_clr_o,
  output logic            tx_undf_clr_o,
  output logic            rx_ready_clr_o,
  output logic            rx_ovr_clr_o,
  output logic            single_set_o,
  output logic            acc_ready_set_o,
  output logic            master_clr_o
);
  pack_op_e        op;
  pack_flag_t      flag;
  logic [2*BW-1:0] half_in, low;

  i2c_pack_ctrl #(.BYTES(BYTES), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .wr_half_i, .wr_byte_i, .rd_i,
    .tx_pop_i, .rx_push_i, .master_rx_i,
    .op_o(op), .tx_cnt_o, .rx_cnt_o, .flag_o(flag)
  );

  // order bit clear: low byte goes out first
  i2c_pack_swap #(.BW(BW), .SWAP_WHEN(1'b0)) u_wr_swap (
    .order_i(big_endian_i), .d_i(wdata_i), .d_o(half_in)
  );

  i2c_pack_store #(.BW(BW), .BYTES(BYTES), .CW(CW)) u_store (
    .clk_i, .rst_ni, .op_i(op), .half_i(half_in), .byte_i(wdata_i[BW-1:0]),
    .push_i(rx_byte_i), .tx_cnt_i(tx_cnt_o), .rx_cnt_i(rx_cnt_o),
    .tx_byte_o, .low_o(low)
  );

  // order bit set: earliest received byte goes to the upper half
  i2c_pack_swap #(.BW(BW), .SWAP_WHEN(1'b1)) u_rd_swap (
    .order_i(big_endian_i), .d_i(low), .d_o(rdata_o)
  );

  assign tx_ready_clr_o  = flag.tx_ready_clr;
  assign tx_undf_clr_o   = flag.tx_undf_clr;
  assign rx_ready_clr_o  = flag.rx_ready_clr;
  assign rx_ovr_clr_o    = flag.rx_ovr_clr;
  assign single_set_o    = flag.single_set;
  assign acc_ready_set_o = flag.acc_ready_set;
  assign master_clr_o    = flag.master_clr;
endmodule

// File: rtl/i2c_pack_buf_chk.sv
module i2c_pack_buf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       wr_half_i,
  input logic       wr_byte_i,
  input logic       rd_i,
  input logic       tx_pop_i,
  input logic       rx_push_i,
  input logic       master_rx_i,
  input logic [2:0] tx_cnt_o,
  input logic [2:0] rx_cnt_o,
  input logic       tx_undf_clr_o,
  input logic       rx_ready_clr_o,
  input logic       rx_ovr_clr_o,
  input logic       single_set_o,
  input logic       acc_ready_set_o,
  input logic       master_clr_o
);
  logic [5:0] strb;
  logic       solo;
  assign strb = {start_i, wr_half_i, wr_byte_i, rd_i, tx_pop_i, rx_push_i};
  assign solo = ($countones(strb) == 1);

  // R2
  half_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && wr_half_i && tx_cnt_o <= 3'd2 |=> tx_cnt_o == $past(tx_cnt_o) + 3'd2);
  // R4
  ignore_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && (wr_half_i || wr_byte_i) && tx_cnt_o > 3'd2 |=>
      tx_cnt_o == $past(tx_cnt_o) && !tx_undf_clr_o);
  // R5
  undf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && (wr_half_i || wr_byte_i) && tx_cnt_o <= 3'd2 |=> tx_undf_clr_o);
  // R6
  pop_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && tx_pop_i && tx_cnt_o != 3'd0 |=> tx_cnt_o == $past(tx_cnt_o) - 3'd1);
  // R7
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_o <= 3'd4);
  // R9
  single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && rd_i && rx_cnt_o == 3'd1 |=> single_set_o && rx_cnt_o == 3'd0);
  // R10
  ovr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && rd_i |=> rx_ovr_clr_o);
  // R10
  acc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo && rd_i && master_rx_i && rx_cnt_o <= 3'd2 |=>
      acc_ready_set_o && master_clr_o && rx_ready_clr_o);
  // R12
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tx_cnt_o == 3'd0 && rx_cnt_o == 3'd0);
endmodule

bind i2c_pack_buf i2c_pack_buf_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wr_half_i(wr_half_i),
  .wr_byte_i(wr_byte_i), .rd_i(rd_i), .tx_pop_i(tx_pop_i), .rx_push_i(rx_push_i),
  .master_rx_i(master_rx_i), .tx_cnt_o(tx_cnt_o), .rx_cnt_o(rx_cnt_o),
  .tx_undf_clr_o(tx_undf_clr_o), .rx_ready_clr_o(rx_ready_clr_o),
  .rx_ovr_clr_o(rx_ovr_clr_o), .single_set_o(single_set_o),
  .acc_ready_set_o(acc_ready_set_o), .master_clr_o(master_clr_o)
);

// File: tb/i2c_pack_buf_test.sv
module i2c_pack_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian, master_rx, start, wr_half, wr_byte, rd, pop, push;
  logic [15:0] wdata, rdata;
  logic [7:0]  tx_byte, rx_byte;
  logic [2:0]  tx_cnt, rx_cnt;
  logic        f_txr, f_und, f_rxr, f_ovr, f_sgl, f_acc, f_mst;
  int          checks = 0;
  int          failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_pack_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian), .master_rx_i(master_rx),
    .start_i(start), .wr_half_i(wr_half), .wr_byte_i(wr_byte), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .tx_pop_i(pop), .tx_byte_o(tx_byte), .tx_cnt_o(tx_cnt),
    .rx_push_i(push), .rx_byte_i(rx_byte), .rx_cnt_o(rx_cnt),
    .tx_ready_clr_o(f_txr), .tx_undf_clr_o(f_und), .rx_ready_clr_o(f_rxr),
    .rx_ovr_clr_o(f_ovr), .single_set_o(f_sgl), .acc_ready_set_o(f_acc),
    .master_clr_o(f_mst)
  );

  // op codes: 0 start, 1 half write, 2 byte write, 3 read, 4 pop, 5 push
  // fields: op[41:39] be[38] data[37:22] expect[21:6] tx[5:3] rx[2:0]
  localparam int NV = 29;
  localparam logic [41:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h0000, 16'h0000, 3'd0, 3'd0},
    {3'd1, 1'b0, 16'h1234, 16'h0000, 3'd2, 3'd0},
    {3'd4, 1'b0, 16'h0000, 16'h0034, 3'd1, 3'd0},
    {3'd4, 1'b0, 16'h0000, 16'h0012, 3'd0, 3'd0},
    {3'd1, 1'b1, 16'hABCD, 16'h0000, 3'd2, 3'd0},
    {3'd4, 1'b1, 16'h0000, 16'h00AB, 3'd1, 3'd0},
    {3'd4, 1'b1, 16'h0000, 16'h00CD, 3'd0, 3'd0},
    {3'd0, 1'b1, 16'h0000, 16'h0000, 3'd0, 3'd0},
    {3'd1, 1'b1, 16'h1122, 16'h0000, 3'd2, 3'd0},
    {3'd2, 1'b1, 16'h0033, 16'h0000, 3'd3, 3'd0},
    {3'd1, 1'b1, 16'h4455, 16'h0000, 3'd3, 3'd0},
    {3'd4, 1'b1, 16'h0000, 16'h0011, 3'd2, 3'd0},
    {3'd4, 1'b1, 16'h0000, 16'h0022, 3'd1, 3'd0},
    {3'd4, 1'b1, 16'h0000, 16'h0033, 3'd0, 3'd0},
    {3'd0, 1'b0, 16'h0000, 16'h0000, 3'd0, 3'd0},
    {3'd5, 1'b0, 16'h00A1, 16'h0000, 3'd0, 3'd1},
    {3'd5, 1'b0, 16'h00B2, 16'h0000, 3'd0, 3'd2},
    {3'd5, 1'b0, 16'h00C3, 16'h0000, 3'd0, 3'd3},
    {3'd3, 1'b0, 16'h0000, 16'hB2A1, 3'd0, 3'd1},
    {3'd3, 1'b0, 16'h0000, 16'h00C3, 3'd0, 3'd0},
    {3'd5, 1'b1, 16'h0010, 16'h0000, 3'd0, 3'd1},
    {3'd5, 1'b1, 16'h0020, 16'h0000, 3'd0, 3'd2},
    {3'd5, 1'b1, 16'h0030, 16'h0000, 3'd0, 3'd3},
    {3'd5, 1'b1, 16'h0040, 16'h0000, 3'd0, 3'd4},
    {3'd5, 1'b1, 16'h0050, 16'h0000, 3'd0, 3'd4},
    {3'd3, 1'b1, 16'h0000, 16'h1020, 3'd0, 3'd2},
    {3'd3, 1'b1, 16'h0000, 16'h3040, 3'd0, 3'd0},
    {3'd3, 1'b0, 16'h0000, 16'h4030, 3'd0, 3'd0},
    {3'd4, 1'b0, 16'h0000, 16'h0000, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    start = 0; wr_half = 0; wr_byte = 0; rd = 0; pop = 0; push = 0;
  endtask

  task automatic drive(input int k, input logic [15:0] d, input logic be);
    idle();
    big_endian = be;
    wdata = d;
    rx_byte = d[7:0];
    case (k)
      0: start = 1;
      1: wr_half = 1;
      2: wr_byte = 1;
      3: rd = 1;
      4: pop = 1;
      default: push = 1;
    endcase
    #1;
  endtask

  // registered results valid one edge later; sample at following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    big_endian = 0; master_rx = 0; wdata = 0; rx_byte = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 tx_cnt", 16'(tx_cnt), 16'h0);
    chk("R1 rx_cnt", 16'(rx_cnt), 16'h0);
    chk("R1 pulses", 16'({f_txr, f_und, f_rxr, f_ovr, f_sgl, f_acc, f_mst}), 16'h0);
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 tx_byte", 16'(tx_byte), 16'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R6 R7 R8 R11 R12: table walk
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      drive(int'(v[41:39]), v[37:22], v[38]);
      if (v[41:39] == 3'd3) chk("R8 R11 rdata", rdata, v[21:6]);
      if (v[41:39] == 3'd4) chk("R2 R3 R6 tx_byte", 16'(tx_byte), v[21:6]);
      step();
      chk("R2 R3 R4 R6 R12 tx_cnt", 16'(tx_cnt), 16'(v[5:3]));
      chk("R7 R8 R11 rx_cnt", 16'(rx_cnt), 16'(v[2:0]));
    end

    // R5 pulses on accepted writes
    drive(0, 16'h0, 1'b1); step();
    drive(1, 16'h0102, 1'b1); step();
    chk("R5 undf on half write", 16'(f_und), 16'h1);
    chk("R5 no ready clr at 2", 16'(f_txr), 16'h0);
    drive(2, 16'h0003, 1'b1); step();
    chk("R5 undf on byte write", 16'(f_und), 16'h1);
    chk("R5 ready clr at 3", 16'(f_txr), 16'h1);
    // R4 refused write leaves no trace
    drive(1, 16'hEEEE, 1'b1); step();
    chk("R4 no pulses", 16'({f_und, f_txr}), 16'h0);
    chk("R4 tx_cnt", 16'(tx_cnt), 16'h3);
    chk("R4 oldest byte kept", 16'(tx_byte), 16'h0001);

    // R13 priority
    drive(0, 16'h5555, 1'b0); wr_half = 1; #1; step();
    chk("R13 start beats write", 16'(tx_cnt), 16'h0);
    drive(3, 16'h0077, 1'b0); push = 1; #1; step();
    chk("R13 read beats push", 16'(rx_cnt), 16'h0);
    chk("R13 read acted", 16'(f_ovr), 16'h1);

    // R9 R10 single byte read as master receiver
    drive(5, 16'h005A, 1'b0); step();
    master_rx = 1;
    drive(3, 16'h0, 1'b0);
    chk("R9 rdata", rdata, 16'h005A);
    step();
    master_rx = 0;
    chk("R9 single pulse", 16'(f_sgl), 16'h1);
    chk("R9 rx_cnt", 16'(rx_cnt), 16'h0);
    chk("R10 rx ready clr", 16'(f_rxr), 16'h1);
    chk("R10 acc ready + master clr", 16'({f_acc, f_mst}), 16'h3);

    // R10 two-byte read, not master
    drive(5, 16'h0061, 1'b0); step();
    drive(5, 16'h0062, 1'b0); step();
    drive(3, 16'h0, 1'b0); step();
    chk("R10 rx ready clr", 16'(f_rxr), 16'h1);
    chk("R10 ovr clr", 16'(f_ovr), 16'h1);
    chk("R10 no acc/master/single", 16'({f_acc, f_mst, f_sgl}), 16'h0);

    // R12 start wipes contents
    drive(1, 16'hFFFF, 1'b0); step();
    drive(0, 16'h0, 1'b0); step();
    chk("R12 rdata zero", rdata, 16'h0);
    chk("R12 pulses idle", 16'({f_txr, f_und, f_rxr, f_ovr, f_sgl, f_acc, f_mst}), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule